// File: doc/BRIEF.md
# Maskable Interrupt Latch Controller

This block collects sixteen interrupt sources for a small 8-bit core. Each source line is edge-detected into a request latch. A winner is chosen among the latches that may be taken, and it is offered to the core as a request on a valid/ready pair. Sources 0 to 3 are non-maskable. Sources 4 to 15 also need their own enable bit and a global interrupt-enable bit. Software sees the enable word and the latch word as four bytes at consecutive byte addresses.

When the core takes a request, the block does three things in that cycle. It reports the source number. It presents the current global-enable value so the core can stack it. It clears the winner's latch, and the global enable reads 0 from the next cycle. A return-from-interrupt pulse loads the global enable from the value the core restored. Software can clear a latch but can never set one. The latches of sources 2 and 3 cannot be cleared by software at all, so only acceptance removes them.

The request side follows valid/ready rules. `irq_valid` stays high for as long as an acceptable latch is pending, whether or not `irq_ready` is high. It is not a held transfer: if a higher-priority source arrives first, `irq_vector` may change before the core accepts. A transfer happens only in a cycle where both `irq_valid` and `irq_ready` are high. `irq_ready` has no effect while `irq_valid` is low.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the global enable, every per-source enable bit, every latch and `irq_valid` are 0.
- R2: A 0-to-1 transition on `src_req[i]` sets latch i at the next clock edge. A line that stays high does not set the latch again after it has been cleared.
- R3: The register map, relative to `BASE_ADDR` (default 0x3A), is: +0 enable bits 7:0, where bit 0 is the global enable; +1 enable bits 15:8; +2 latch bits 7:0; +3 latch bits 15:8. A write to an enable byte stores it as written. Reading any of the four bytes returns its current contents. Any other address reads 0.
- R4: Writing 0 to a latch bit clears that latch. Writing 1 leaves it unchanged.
- R5: Software writes never clear latch 2 or latch 3.
- R6: If a source edge and a software clear of the same latch fall in the same cycle, the latch ends up set.
- R7: A source at index 4 or higher is a candidate only when the global enable is 1 and its own enable bit is 1.
- R8: Sources 0 to 3 are candidates whenever their latch is set, whatever the enable bits hold.
- R9: Among the candidates, the lowest index is presented on `irq_vector`.
- R10: A transfer (`irq_valid` and `irq_ready` both high) presents the current global enable on `irq_saved_ime`. At that edge it clears the winning latch and clears the global enable.
- R11: `reti_pulse` loads the global enable from `reti_ime`. If a transfer happens in the same cycle, the global enable is cleared instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 16 | Interrupt source lines, captured on rising edges |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_valid | output | 1 | A request is available for the core |
| irq_ready | input | 1 | The core accepts the offered request |
| irq_vector | output | 4 | Index of the offered source |
| irq_saved_ime | output | 1 | Global enable value to be stacked on acceptance |
| reti_pulse | input | 1 | Return from interrupt |
| reti_ime | input | 1 | Restored global enable value |

## Verification
A table drives source patterns against enable words. It covers a single maskable source with everything enabled, the same source with only the global bit off, and the same source with only its own bit off, which separates the two masking terms. It also covers non-maskable sources with every enable cleared, and mixed patterns in which a lower maskable index competes with a higher one, or a non-maskable index competes with maskable ones, which checks the priority order. Directed cases cover the write-to-clear semantics and the protected latches. They also cover a held source line after a clear, an edge that collides with a software clear, the full accept-and-return sequence, and an accept that lands in the same cycle as a return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC   = 16;
  localparam int unsigned NBYTES = NSRC / 8;
  localparam int unsigned IDX_W  = $clog2(NSRC);

  typedef enum logic [1:0] {
    SEL_EN_LO = 2'd0,
    SEL_EN_HI = 2'd1,
    SEL_LT_LO = 2'd2,
    SEL_LT_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [7:0]      wdata,
  input  logic            accept,
  input  logic            reti,
  input  logic            reti_ime,
  output logic [NSRC-1:0] en_word
);
  logic [NSRC-1:1] en_q;
  logic            ime_q;
  logic            ime_n;

  // priority: acceptance, then return, then software
  always_comb begin
    if (accept)     ime_n = 1'b0;
    else if (reti)  ime_n = reti_ime;
    else if (wr_lo) ime_n = wdata[0];
    else            ime_n = ime_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ime_q <= 1'b0;
    end else begin
      ime_q <= ime_n;
      if (wr_lo) en_q[7:1]  <= wdata[7:1];
      if (wr_hi) en_q[15:8] <= wdata;
    end
  end

  assign en_word = {en_q, ime_q};

  assert_ime_off_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !en_word[0]);

  assert_reti_restores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !accept) |=> (en_word[0] == $past(reti_ime)));
endmodule

// File: rtl/irqc_latches.sv
module irqc_latches
  import irqc_pkg::*;
#(
  parameter logic [NSRC-1:0] PROT_MASK = 16'h000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic [NBYTES-1:0] wr_byte,
  input  logic [7:0]        wdata,
  input  logic [NSRC-1:0]   acc_clr,
  output logic [NSRC-1:0]   latch
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] sw_raw;
  logic [NSRC-1:0] sw_clr;

  assign rise = src & ~src_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign sw_raw[b*8 +: 8] = {8{wr_byte[b]}} & ~wdata;
  end

  assign sw_clr = sw_raw & ~PROT_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      latch <= '0;
    end else begin
      src_q <= src;
      latch <= (latch & ~sw_clr & ~acc_clr) | rise;
    end
  end

  assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch & ~$past(latch) & ~$past(rise)) == '0));

  assert_protected_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch) & PROT_MASK & ~$past(acc_clr) & ~latch) == '0));

  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~latch) == '0));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned N_NMI = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  latch,
  input  logic [NSRC-1:0]  en_word,
  output logic             valid,
  output logic [IDX_W-1:0] vector,
  output logic [NSRC-1:0]  grant
);
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] cand;

  for (genvar i = 0; i < NSRC; i++) begin : g_allow
    if (i < N_NMI) begin : g_nmi
      assign allow[i] = 1'b1;
    end else begin : g_mask
      assign allow[i] = en_word[0] & en_word[i];
    end
  end

  assign cand  = latch & allow;
  assign valid = |cand;
  assign grant = cand & (~cand + {{(NSRC-1){1'b0}}, 1'b1});

  always_comb begin
    vector = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) vector = IDX_W'(i);
    end
  end

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (valid == (grant != '0)));

  assert_masked_needs_ime_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (32'(vector) >= N_NMI)) |-> (en_word[0] && latch[vector]));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h3A,
  parameter int unsigned     N_NMI     = 4,
  parameter logic [NSRC-1:0] PROT_MASK = 16'h000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [IDX_W-1:0]  irq_vector,
  output logic              irq_saved_ime,
  input  logic              reti_pulse,
  input  logic              reti_ime
);
  localparam int unsigned NREG = 2 * NBYTES;

  logic [ADDR_W-1:0] off;
  logic              hit;
  reg_sel_e          sel;
  logic [NSRC-1:0]   en_word;
  logic [NSRC-1:0]   latch;
  logic [NSRC-1:0]   grant;
  logic [NSRC-1:0]   acc_clr;
  logic              accept;
  logic              wr_en_lo, wr_en_hi;
  logic [NBYTES-1:0] wr_lt;

  assign off = reg_addr - BASE_ADDR;
  assign hit = (off < ADDR_W'(NREG));
  assign sel = reg_sel_e'(off[1:0]);

  assign wr_en_lo = reg_we & hit & (sel == SEL_EN_LO);
  assign wr_en_hi = reg_we & hit & (sel == SEL_EN_HI);
  assign wr_lt    = {reg_we & hit & (sel == SEL_LT_HI),
                     reg_we & hit & (sel == SEL_LT_LO)};

  assign accept  = irq_valid & irq_ready;
  assign acc_clr = accept ? grant : '0;

  irqc_enable_regs u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_en_lo),
    .wr_hi    (wr_en_hi),
    .wdata    (reg_wdata),
    .accept   (accept),
    .reti     (reti_pulse),
    .reti_ime (reti_ime),
    .en_word  (en_word)
  );

  irqc_latches #(.PROT_MASK(PROT_MASK)) u_lt (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src_req),
    .wr_byte (wr_lt),
    .wdata   (reg_wdata),
    .acc_clr (acc_clr),
    .latch   (latch)
  );

  irqc_arbiter #(.N_NMI(N_NMI)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch   (latch),
    .en_word (en_word),
    .valid   (irq_valid),
    .vector  (irq_vector),
    .grant   (grant)
  );

  assign irq_saved_ime = en_word[0];

  always_comb begin
    reg_rdata = 8'h00;
    if (hit) begin
      unique case (sel)
        SEL_EN_LO: reg_rdata = en_word[7:0];
        SEL_EN_HI: reg_rdata = en_word[15:8];
        SEL_LT_LO: reg_rdata = latch[7:0];
        SEL_LT_HI: reg_rdata = latch[15:8];
      endcase
    end
  end

  assert_accept_clears_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !latch[$past(irq_vector)] || $past(src_req[irq_vector]));
endmodule

// File: tb/irq_latch_ctrl_tb.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb;
  typedef struct packed {
    logic [15:0] src;
    logic [15:0] en;
    logic        vld;
    logic [3:0]  vec;
  } vec_t;

  // R7 R8 R9: source pattern, enable word (bit0 = global enable), expected result
  localparam vec_t TBL [10] = '{
    '{16'h0010, 16'h0011, 1'b1, 4'd4},
    '{16'h0010, 16'h0010, 1'b0, 4'd0},
    '{16'h0010, 16'h0001, 1'b0, 4'd0},
    '{16'h0004, 16'h0000, 1'b1, 4'd2},
    '{16'h8020, 16'hFFFF, 1'b1, 4'd5},
    '{16'h8000, 16'h8001, 1'b1, 4'd15},
    '{16'h0009, 16'h0000, 1'b1, 4'd0},
    '{16'h0102, 16'hFFFF, 1'b1, 4'd1},
    '{16'h0F00, 16'h0C01, 1'b1, 4'd10},
    '{16'hFFF0, 16'h0000, 1'b0, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_req = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [3:0]  irq_vector;
  logic        irq_saved_ime;
  logic        reti_pulse = 1'b0;
  logic        reti_ime = 1'b0;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .irq_saved_ime(irq_saved_ime), .reti_pulse(reti_pulse), .reti_ime(reti_ime)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    check(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic pulse_src(input logic [15:0] p);
    src_req = p;
    @(negedge clk);
    src_req = '0;
    @(negedge clk);
  endtask

  task automatic accept_one();
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic drain();
    wr(8'h3C, 8'h00);
    wr(8'h3D, 8'h00);
    for (int k = 0; k < 6; k++) begin
      if (irq_valid) accept_one();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {15'd0, irq_valid}, 16'd0);
    rd("R1 en_lo", 8'h3A, 8'h00);
    rd("R1 en_hi", 8'h3B, 8'h00);
    rd("R1 lt_lo", 8'h3C, 8'h00);
    rd("R1 lt_hi", 8'h3D, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R7 R8 R9
    for (int t = 0; t < 10; t++) begin
      wr(8'h3A, TBL[t].en[7:0]);
      wr(8'h3B, TBL[t].en[15:8]);
      pulse_src(TBL[t].src);
      check($sformatf("R7/R8 valid entry %0d", t), {15'd0, irq_valid}, {15'd0, TBL[t].vld});
      if (TBL[t].vld)
        check($sformatf("R9 vector entry %0d", t), {12'd0, irq_vector}, {12'd0, TBL[t].vec});
      drain();
    end

    // R3 map: out-of-range addresses and stored enable bytes
    rd("R3 below base", 8'h39, 8'h00);
    rd("R3 above range", 8'h3E, 8'h00);
    wr(8'h3B, 8'hA5);
    rd("R3 en_hi readback", 8'h3B, 8'hA5);
    wr(8'h3A, 8'h5A);
    rd("R3 en_lo readback", 8'h3A, 8'h5A);
    wr(8'h3A, 8'h00);
    wr(8'h3B, 8'h00);

    // R4 write-0 clears, write-1 keeps
    pulse_src(16'h0210);
    rd("R2 edge sets lt_lo", 8'h3C, 8'h10);
    wr(8'h3C, 8'hEF);
    rd("R4 clear bit4", 8'h3C, 8'h00);
    wr(8'h3D, 8'hFF);
    rd("R4 write ones keeps", 8'h3D, 8'h02);
    wr(8'h3D, 8'h00);
    rd("R4 clear bit9", 8'h3D, 8'h00);

    // R2 held line does not re-set
    src_req = 16'h0080;
    @(negedge clk);
    wr(8'h3C, 8'h7F);
    @(negedge clk);
    rd("R2 held line no reset", 8'h3C, 8'h00);
    src_req = '0;
    @(negedge clk);

    // R5 protected latches
    pulse_src(16'h000C);
    wr(8'h3C, 8'h00);
    rd("R5 protected kept", 8'h3C, 8'h0C);
    check("R9 nmi order", {12'd0, irq_vector}, 16'd2);
    accept_one();
    check("R9 next nmi", {12'd0, irq_vector}, 16'd3);
    accept_one();
    rd("R10 protected cleared by accept", 8'h3C, 8'h00);

    // R6 edge beats software clear
    src_req = 16'h0040; reg_addr = 8'h3C; reg_wdata = 8'h00; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; src_req = '0;
    @(negedge clk);
    rd("R6 edge wins", 8'h3C, 8'h40);
    wr(8'h3C, 8'h00);

    // R10 accept sequence
    wr(8'h3A, 8'h21);
    pulse_src(16'h0020);
    check("R10 valid", {15'd0, irq_valid}, 16'd1);
    check("R10 vector", {12'd0, irq_vector}, 16'd5);
    check("R10 saved ime", {15'd0, irq_saved_ime}, 16'd1);
    accept_one();
    check("R10 valid after", {15'd0, irq_valid}, 16'd0);
    rd("R10 ime cleared", 8'h3A, 8'h20);
    rd("R10 latch cleared", 8'h3C, 8'h00);

    // R11 return restores
    reti_pulse = 1'b1; reti_ime = 1'b1;
    @(negedge clk);
    reti_pulse = 1'b0;
    rd("R11 ime restored", 8'h3A, 8'h21);

    // R11 accept beats return in same cycle
    pulse_src(16'h0001);
    check("R8 nmi vector0", {12'd0, irq_vector}, 16'd0);
    irq_ready = 1'b1; reti_pulse = 1'b1; reti_ime = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0; reti_pulse = 1'b0;
    rd("R11 accept wins", 8'h3A, 8'h20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule